// File: doc/BRIEF.md
# Hit-Under-Miss Data Cache Controller

This block is the control and storage logic of a small direct-mapped, read-only data cache that keeps serving hits while a single miss waits on the next memory level. Each request carries a word address and a tag (request ID). A request that finds its block in the cache returns the addressed word through a four-stage pipeline. A request that misses captures the one miss register, and the block sends a one-cycle line request to the next level. The next level answers with the full 64-byte line ten cycles later.

While the miss is outstanding, requests that hit go on being accepted and answered. Their responses can therefore overtake the response of the earlier miss, so every response carries the ID of its request. The block lowers `req_ready` in three cases: a second miss arrives, a request touches the block being fetched, or the refill is being installed. When the line arrives it is written into its set, the waiting requester's word re-enters the response pipeline with its ID, and the miss register frees.

Addresses are word addresses of 32-bit words. With the defaults, the low 4 bits select the word within a line, the next 4 bits select the set (16 sets), and the top 6 bits form the tag.

Top module: `hum_cache_ctrl`

## Requirements
- R1: After reset no line is valid, `rsp_valid` and `mem_req_valid` are low, and a presented request sees `req_ready` high.
- R2: A request accepted in cycle c that hits returns its word on `rsp_data` with its ID on `rsp_id` while `rsp_valid` is high in cycle c+4.
- R3: A missing request accepted in cycle c while the miss register is free raises `mem_req_valid` for exactly cycle c+1, with `mem_req_line` equal to the request address with its low 4 word-offset bits removed.
- R4: While a miss is outstanding, a request that hits a block other than the pending one is accepted and answered with the R2 timing.
- R5: While a miss is outstanding, a request that misses holds `req_ready` low until the miss register is free.
- R6: While a miss is outstanding, a request whose line address equals the pending line holds `req_ready` low.
- R7: In the cycle r where `mem_rsp_valid` is high, `req_ready` is low. The line is installed so that later accesses to it hit, and the missing requester's word returns with its ID in cycle r+4.
- R8: Responses may leave in a different order from requests, and each response carries exactly the ID of one accepted request, once.
- R9: At most one line request is outstanding at the next level at any time.
- R10: The returned word is the one selected by the word offset (address bits [3:0]) within the 16-word line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with `req_valid` |
| req_id | input | 4 | Request tag returned with the response |
| req_addr | input | 14 | Word address |
| rsp_valid | output | 1 | Response present |
| rsp_id | output | 4 | Tag of the answered request |
| rsp_data | output | 32 | Requested word |
| mem_req_valid | output | 1 | One-cycle line request to next level |
| mem_req_line | output | 10 | Line address of the pending miss |
| mem_rsp_valid | input | 1 | Refill line present |
| mem_rsp_line_data | input | 512 | Refill line, word w in bits [32w+31:32w] |

## Verification
The bench targets a hit that arrives while a miss is outstanding. If that hit were stalled, the `req_ready` check would fire. If it were answered in program order, the response cycle would be wrong. A second miss and an access to the pending block are held against the refill cycle. A design that let either one through would raise a second line request or return the stale word, and a design that kept stalling after the refill would fail the ready prediction. The refill cycle itself must block new requests and return the first requester's word four cycles later with its own ID. An off-by-one in the word select or in the hit pipeline depth shows up as a wrong word or a wrong response cycle on randomly mixed hits and misses.

// File: rtl/hum_pkg.sv
package hum_pkg;
  typedef enum logic {
    MR_FREE = 1'b0,
    MR_BUSY = 1'b1
  } mr_state_e;
endpackage

// File: rtl/hum_tag_store.sv
module hum_tag_store #(
  parameter int SETS      = 16,
  parameter int IDX_W     = 4,
  parameter int TAG_W     = 6,
  parameter int WOFF_W    = 4,
  parameter int WORD_W    = 32,
  parameter int LINE_BITS = 512
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [IDX_W-1:0]     rd_idx,
  input  logic [TAG_W-1:0]     rd_tag,
  input  logic [WOFF_W-1:0]    rd_woff,
  output logic                 rd_hit,
  output logic [WORD_W-1:0]    rd_word,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [TAG_W-1:0]     wr_tag,
  input  logic [LINE_BITS-1:0] wr_line
);
  logic [SETS-1:0]      vld_q;
  logic [TAG_W-1:0]     tag_q  [SETS];
  logic [LINE_BITS-1:0] line_q [SETS];
  logic [LINE_BITS-1:0] sel_line;

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic                 set_we;
    logic                 vld_r;
    logic [TAG_W-1:0]     tag_r;
    logic [LINE_BITS-1:0] line_r;

    assign set_we = wr_en && (wr_idx == IDX_W'(s));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_r <= 1'b0;
      end else if (set_we) begin
        vld_r <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (set_we) begin
        tag_r  <= wr_tag;
        line_r <= wr_line;
      end
    end

    assign vld_q[s]  = vld_r;
    assign tag_q[s]  = tag_r;
    assign line_q[s] = line_r;
  end

  always_comb begin
    sel_line = line_q[rd_idx];
    rd_hit   = vld_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
    rd_word  = sel_line[rd_woff*WORD_W +: WORD_W];
  end
endmodule

// File: rtl/hum_miss_reg.sv
module hum_miss_reg
  import hum_pkg::*;
#(
  parameter int ID_W    = 4,
  parameter int LADDR_W = 10,
  parameter int WOFF_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               alloc,
  input  logic [ID_W-1:0]    alloc_id,
  input  logic [LADDR_W-1:0] alloc_line,
  input  logic [WOFF_W-1:0]  alloc_woff,
  input  logic               release_i,
  output logic               busy,
  output logic [ID_W-1:0]    pend_id,
  output logic [LADDR_W-1:0] pend_line,
  output logic [WOFF_W-1:0]  pend_woff,
  output logic               memreq
);
  mr_state_e          state_q, state_d;
  logic               memreq_q;
  logic [ID_W-1:0]    id_q;
  logic [LADDR_W-1:0] line_q;
  logic [WOFF_W-1:0]  woff_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      MR_FREE: if (alloc)     state_d = MR_BUSY;
      MR_BUSY: if (release_i) state_d = MR_FREE;
      default: state_d = MR_FREE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= MR_FREE;
      memreq_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      memreq_q <= alloc;
    end
  end

  always_ff @(posedge clk) begin
    if (alloc) begin
      id_q   <= alloc_id;
      line_q <= alloc_line;
      woff_q <= alloc_woff;
    end
  end

  assign busy      = (state_q == MR_BUSY);
  assign pend_id   = id_q;
  assign pend_line = line_q;
  assign pend_woff = woff_q;
  assign memreq    = memreq_q;
endmodule

// File: rtl/hum_hit_pipe.sv
module hum_hit_pipe #(
  parameter int DEPTH  = 4,
  parameter int ID_W   = 4,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [ID_W-1:0]   in_id,
  input  logic [WORD_W-1:0] in_data,
  output logic              out_valid,
  output logic [ID_W-1:0]   out_id,
  output logic [WORD_W-1:0] out_data
);
  logic              stg_v [DEPTH];
  logic [ID_W-1:0]   stg_id [DEPTH];
  logic [WORD_W-1:0] stg_d [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    logic              src_v;
    logic [ID_W-1:0]   src_id;
    logic [WORD_W-1:0] src_d;
    logic              v_r;
    logic [ID_W-1:0]   id_r;
    logic [WORD_W-1:0] d_r;

    if (s == 0) begin : g_head
      assign src_v  = in_valid;
      assign src_id = in_id;
      assign src_d  = in_data;
    end else begin : g_body
      assign src_v  = stg_v[s-1];
      assign src_id = stg_id[s-1];
      assign src_d  = stg_d[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_r <= 1'b0;
      end else begin
        v_r <= src_v;
      end
    end

    always_ff @(posedge clk) begin
      if (src_v) begin
        id_r <= src_id;
        d_r  <= src_d;
      end
    end

    assign stg_v[s]  = v_r;
    assign stg_id[s] = id_r;
    assign stg_d[s]  = d_r;
  end

  assign out_valid = stg_v[DEPTH-1];
  assign out_id    = stg_id[DEPTH-1];
  assign out_data  = stg_d[DEPTH-1];
endmodule

// File: rtl/hum_cache_ctrl.sv
module hum_cache_ctrl #(
  parameter int ADDR_W     = 14,
  parameter int WORD_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int SETS       = 16,
  parameter int ID_W       = 4,
  parameter int HIT_LAT    = 4,
  localparam int LINE_BITS = LINE_BYTES * 8,
  localparam int WORDS     = LINE_BITS / WORD_W,
  localparam int WOFF_W    = $clog2(WORDS),
  localparam int IDX_W     = $clog2(SETS),
  localparam int LADDR_W   = ADDR_W - WOFF_W,
  localparam int TAG_W     = LADDR_W - IDX_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [ID_W-1:0]      req_id,
  input  logic [ADDR_W-1:0]    req_addr,
  output logic                 rsp_valid,
  output logic [ID_W-1:0]      rsp_id,
  output logic [WORD_W-1:0]    rsp_data,
  output logic                 mem_req_valid,
  output logic [LADDR_W-1:0]   mem_req_line,
  input  logic                 mem_rsp_valid,
  input  logic [LINE_BITS-1:0] mem_rsp_line_data
);
  logic [LADDR_W-1:0] req_line;
  logic [IDX_W-1:0]   req_idx;
  logic [TAG_W-1:0]   req_tag;
  logic [WOFF_W-1:0]  req_woff;
  logic               lkp_hit;
  logic [WORD_W-1:0]  lkp_word;
  logic               mr_busy;
  logic [ID_W-1:0]    mr_id;
  logic [LADDR_W-1:0] mr_line;
  logic [WOFF_W-1:0]  mr_woff;
  logic               same_blk;
  logic               stall;
  logic               accept;
  logic               alloc;
  logic               refill;
  logic [WORD_W-1:0]  refill_word;
  logic               pipe_v;
  logic [ID_W-1:0]    pipe_id;
  logic [WORD_W-1:0]  pipe_d;

  assign req_woff = req_addr[WOFF_W-1:0];
  assign req_line = req_addr[ADDR_W-1:WOFF_W];
  assign req_idx  = req_line[IDX_W-1:0];
  assign req_tag  = req_line[LADDR_W-1:IDX_W];

  hum_tag_store #(
    .SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W), .WOFF_W(WOFF_W),
    .WORD_W(WORD_W), .LINE_BITS(LINE_BITS)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_idx  (req_idx),
    .rd_tag  (req_tag),
    .rd_woff (req_woff),
    .rd_hit  (lkp_hit),
    .rd_word (lkp_word),
    .wr_en   (refill),
    .wr_idx  (mr_line[IDX_W-1:0]),
    .wr_tag  (mr_line[LADDR_W-1:IDX_W]),
    .wr_line (mem_rsp_line_data)
  );

  always_comb begin
    same_blk    = mr_busy && (req_line == mr_line);
    stall       = mem_rsp_valid || (mr_busy && (!lkp_hit || same_blk));
    req_ready   = !stall;
    accept      = req_valid && req_ready;
    alloc       = accept && !lkp_hit;
    refill      = mem_rsp_valid && mr_busy;
    refill_word = mem_rsp_line_data[mr_woff*WORD_W +: WORD_W];
    pipe_v      = (accept && lkp_hit) || refill;
    pipe_id     = refill ? mr_id : req_id;
    pipe_d      = refill ? refill_word : lkp_word;
  end

  hum_miss_reg #(
    .ID_W(ID_W), .LADDR_W(LADDR_W), .WOFF_W(WOFF_W)
  ) u_mreg (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc      (alloc),
    .alloc_id   (req_id),
    .alloc_line (req_line),
    .alloc_woff (req_woff),
    .release_i  (refill),
    .busy       (mr_busy),
    .pend_id    (mr_id),
    .pend_line  (mr_line),
    .pend_woff  (mr_woff),
    .memreq     (mem_req_valid)
  );

  assign mem_req_line = mr_line;

  hum_hit_pipe #(
    .DEPTH(HIT_LAT), .ID_W(ID_W), .WORD_W(WORD_W)
  ) u_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (pipe_v),
    .in_id     (pipe_id),
    .in_data   (pipe_d),
    .out_valid (rsp_valid),
    .out_id    (rsp_id),
    .out_data  (rsp_data)
  );
endmodule

// File: rtl/hum_cache_ctrl_chk.sv
module hum_cache_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic mem_req_valid,
  input logic mem_rsp_valid,
  input logic lkp_hit
);
  logic outst_q;
  logic chk_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outst_q <= 1'b0;
    end else if (mem_req_valid) begin
      outst_q <= 1'b1;
    end else if (mem_rsp_valid) begin
      outst_q <= 1'b0;
    end
  end

  assign chk_busy = outst_q || mem_req_valid;

  AST_MEMREQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !mem_req_valid); // R3
  AST_MEMREQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> $past(req_valid && req_ready)); // R3
  AST_SINGLE_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !outst_q); // R9
  AST_REFILL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |-> !req_ready); // R7
  AST_SECOND_MISS_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_busy && req_valid && !lkp_hit) |-> !req_ready); // R5
endmodule

bind hum_cache_ctrl hum_cache_ctrl_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .mem_req_valid (mem_req_valid),
  .mem_rsp_valid (mem_rsp_valid),
  .lkp_hit       (lkp_hit)
);

// File: tb/hum_cache_ctrl_tb.sv
`timescale 1ns/1ps
module hum_cache_ctrl_tb;
  logic         clk;
  logic         rst_n;
  logic         req_valid;
  logic         req_ready;
  logic [3:0]   req_id;
  logic [13:0]  req_addr;
  logic         rsp_valid;
  logic [3:0]   rsp_id;
  logic [31:0]  rsp_data;
  logic         mem_req_valid;
  logic [9:0]   mem_req_line;
  logic         mem_rsp_valid;
  logic [511:0] mem_rsp_line_data;

  hum_cache_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_id(req_id), .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_id(rsp_id),
    .rsp_data(rsp_data), .mem_req_valid(mem_req_valid), .mem_req_line(mem_req_line),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_line_data(mem_rsp_line_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  bit done = 0;

  bit         mv [16];
  logic [5:0] mt [16];
  bit         mbusy;
  logic [9:0] mlad;
  bit         ev [16];
  int         ec [16];
  logic [31:0] ed [16];
  string      er [16];
  bit         mp;
  int         mcyc;
  logic [9:0] mline;
  int         xmr_cyc;
  logic [9:0] xmr_line;
  bit         dv;
  logic [13:0] da;
  logic [3:0] nid;
  bit         acc_last;

  function automatic logic [31:0] mem_word(logic [13:0] wa);
    return (32'(wa) * 32'h9E37_79B1) ^ 32'h5A5A_0000;
  endfunction

  function automatic logic [511:0] line_of(logic [9:0] l);
    logic [511:0] r;
    for (int w = 0; w < 16; w++) r[w*32 +: 32] = mem_word({l, 4'(w)});
    return r;
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic step();
    logic [9:0] la;
    logic [3:0] ix;
    logic [5:0] tg;
    bit hitm, rdy_exp;
    string rtag;
    if (rsp_valid) begin
      chk(ev[rsp_id], "R8", "response id not outstanding", 64'(rsp_id), 64'(rsp_id));
      if (ev[rsp_id]) begin
        chk(ec[rsp_id] == cyc, er[rsp_id], "response cycle", 64'(cyc), 64'(ec[rsp_id]));
        chk(rsp_data == ed[rsp_id], "R10", "response word", 64'(rsp_data), 64'(ed[rsp_id]));
        ev[rsp_id] = 0;
      end
    end
    for (int i = 0; i < 16; i++) begin
      if (ev[i] && ec[i] < cyc) begin
        chk(0, er[i], "response missing", 64'(cyc), 64'(ec[i]));
        ev[i] = 0;
      end
    end
    if (mem_req_valid) begin
      chk(!mp, "R9", "line request while one outstanding", 64'(1), 64'(0));
      chk(cyc == xmr_cyc && mem_req_line == xmr_line, "R3", "line request cycle/line",
          64'(mem_req_line), 64'(xmr_line));
      mp = 1; mcyc = cyc + 10; mline = mem_req_line;
    end else if (cyc == xmr_cyc) begin
      chk(0, "R3", "missing line request", 64'(0), 64'(1));
    end
    if (mp && cyc == mcyc) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_line_data = line_of(mline);
    end else begin
      mem_rsp_valid = 1'b0;
    end
    req_valid = dv;
    req_addr  = da;
    req_id    = nid;
    #1;
    la = da[13:4]; ix = la[3:0]; tg = la[9:4];
    hitm = mv[ix] && (mt[ix] == tg);
    rdy_exp = !mem_rsp_valid && !(mbusy && (!hitm || la == mlad));
    if (mem_rsp_valid)                rtag = "R7";
    else if (mbusy && la == mlad)     rtag = "R6";
    else if (mbusy && !hitm)          rtag = "R5";
    else if (mbusy)                   rtag = "R4";
    else                              rtag = "R2";
    if (dv) chk(req_ready == rdy_exp, rtag, "req_ready", 64'(req_ready), 64'(rdy_exp));
    acc_last = dv && req_ready;
    if (acc_last) begin
      ev[nid] = 1;
      ed[nid] = mem_word(da);
      if (hitm) begin
        ec[nid] = cyc + 4;
        er[nid] = mbusy ? "R4" : "R2";
      end else begin
        ec[nid] = cyc + 15;
        er[nid] = "R7";
        mbusy = 1; mlad = la;
        xmr_cyc = cyc + 1; xmr_line = la;
      end
      nid++;
    end
    if (mem_rsp_valid) begin
      mv[mline[3:0]] = 1;
      mt[mline[3:0]] = mline[9:4];
      mbusy = 0;
      mp = 0;
    end
    cyc++;
    @(negedge clk);
  endtask

  task automatic issue(logic [13:0] a);
    dv = 1; da = a;
    do step(); while (!acc_last);
    dv = 0;
  endtask

  task automatic idle(int k);
    repeat (k) step();
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 16; i++) begin mv[i] = 0; ev[i] = 0; mt[i] = '0; end
    mbusy = 0; mlad = '0; mp = 0; mcyc = 0; mline = '0; xmr_cyc = -1; xmr_line = '0;
    dv = 0; da = '0; nid = '0; acc_last = 0;
    rst_n = 1'b0; req_valid = 1'b0; req_id = '0; req_addr = '0;
    mem_rsp_valid = 1'b0; mem_rsp_line_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    req_valid = 1'b1; req_addr = 14'h0123;
    #1;
    chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", 64'(rsp_valid), 64'(0));
    chk(mem_req_valid == 1'b0, "R1", "mem_req_valid after reset", 64'(mem_req_valid), 64'(0));
    chk(req_ready == 1'b1, "R1", "req_ready after reset", 64'(req_ready), 64'(1));
    req_valid = 1'b0;
    @(negedge clk);
    // directed: first miss, then hit to same line at another word (R2, R10)
    issue({6'd1, 4'd2, 4'd3});
    idle(16);
    issue({6'd1, 4'd2, 4'd5});
    idle(5);
    // miss B, hit under miss (R4, R8), second miss stalls (R5), pending block stalls (R6)
    issue({6'd2, 4'd5, 4'd0});
    issue({6'd1, 4'd2, 4'd7});
    issue({6'd3, 4'd6, 4'd1});
    issue({6'd3, 4'd6, 4'd9});
    idle(20);
    // random mix
    for (int n = 0; n < 2500; n++) begin
      idle($urandom_range(0, 2));
      issue({6'($urandom_range(0, 2)), 4'($urandom_range(0, 3)), 4'($urandom)});
    end
    idle(24);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: run did not complete (cycle %0d)", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule